// File: doc/BRIEF.md
# Load/Store Address Buffer

This block holds memory operations for a dynamically scheduled core between rename and the memory port. Each operation arrives with a kind (load or store), a base operand, an immediate offset and, for stores, a data operand. An operand arrives either as a real value or as a producer tag. A tag is replaced by a value when the producer broadcasts on the result bus. Each slot has an address field. It first holds the offset. Once the base operand is real, the slot adds the base and keeps the effective address in that same field. Address generation does not depend on data availability, so a store can hold a finished address while it still waits for its data.

Operations go to a single valid/ready memory port strictly in allocation order, and only the oldest slot may request. A load reads memory, gets its data one cycle after the port accepts it, and in that cycle broadcasts the data with its own slot tag. The slot then frees. A store is sent as a write only once its data is real, and its slot frees when the port accepts the write. Only one read is ever in flight.

Top module: `lsab_mem_buffer`

## Requirements
- R1: After reset, `alloc_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: Slots are used in a ring in allocation order. The slot number starts at 0 after reset and wraps after DEPTH-1. `alloc_tag` equals TAG_BASE plus that slot number. `alloc_ready` is 0 while DEPTH slots are held. An allocation presented while `alloc_ready` is 0 is ignored. `alloc_ready` returns in the cycle after a slot frees.
- R3: The effective address is the base value plus the offset. If the base is already real at allocation (tag 0), the request becomes visible after the second rising edge that counts the allocation edge as the first.
- R4: A base given as a nonzero tag is captured from the first valid bus cycle whose tag matches. The request, with address equal to the captured value plus the offset, becomes visible after the edge that follows the capture edge.
- R5: A load issues a read (`mem_req_write`=0). In the cycle after the port accepts it, `res_valid` is 1, `res_tag` is the load's slot tag and `res_value` equals `mem_rsp_data`. The slot frees at the end of that cycle.
- R6: A store does not request until its data operand is real. It then issues a write (`mem_req_write`=1) carrying its effective address and data. Its slot frees on acceptance and it never raises `res_valid`. A request that is not accepted stays valid with unchanged address, kind and data.
- R7: Only the oldest held slot may request. A younger load whose address is ready stays silent while an older store waits for data, so the load reads the value that store writes.
- R8: If the bus broadcasts a matching tag in the same cycle that an operand is allocated with that tag, the operand captures the broadcast value.
- R9: The bus changes no operand when `bus_valid` is 0 or the tag differs. Tag 0 means the value is present and never matches.
- R10: At most one read is outstanding. In the cycle after a read is accepted, `mem_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New memory operation offered |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_base_tag | input | TAG_W | Base producer tag, 0 = value present |
| alloc_base_val | input | DW | Base value when tag is 0 |
| alloc_offset | input | AW | Immediate offset |
| alloc_data_tag | input | TAG_W | Store data producer tag, 0 = present |
| alloc_data_val | input | DW | Store data value when tag is 0 |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TAG_W | Tag of the slot taken by this allocation |
| bus_valid | input | 1 | Result bus carries a value |
| bus_tag | input | TAG_W | Producer tag on the result bus |
| bus_value | input | DW | Value on the result bus |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word-aligned address |
| mem_req_wdata | output | DW | Write data |
| mem_req_ready | input | 1 | Port accepts request |
| mem_rsp_data | input | DW | Read data, one cycle after read acceptance |
| res_valid | output | 1 | Load result broadcast |
| res_tag | output | TAG_W | Tag of the finishing load |
| res_value | output | DW | Loaded data |

## Verification
Two functions can land in the same cycle. One is a result-bus broadcast that arrives in the very cycle an operand naming that tag is allocated. The other is a store's data capture happening while a younger load with a ready address sits behind it. The bench provokes the first by driving the bus and the allocation together. It judges the outcome by the exact request address two edges later. It provokes the second by holding a store's data tag back until a dependent load is queued. It judges that case by the port staying idle, the write preceding the read, and the load returning the stored word.

// File: rtl/lsab_pkg.sv
package lsab_pkg;
    typedef enum logic {
        LSAB_LOAD  = 1'b0,
        LSAB_STORE = 1'b1
    } lsab_kind_e;
endpackage

// File: rtl/lsab_snoop.sv
module lsab_snoop #(
    parameter int TAG_W = 4,
    parameter int DW    = 32
) (
    input  logic [TAG_W-1:0] in_tag,
    input  logic [DW-1:0]    in_val,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    input  logic [DW-1:0]    bus_value,
    output logic [TAG_W-1:0] out_tag,
    output logic [DW-1:0]    out_val
);
    logic hit;

    // A zero tag means the value is already held, so it never matches.
    assign hit = bus_valid && (in_tag != '0) && (in_tag == bus_tag);

    always_comb begin
        out_tag = in_tag;
        out_val = in_val;
        if (hit) begin
            out_tag = '0;
            out_val = bus_value;
        end
    end
endmodule

// File: rtl/lsab_agen.sv
module lsab_agen #(
    parameter int TAG_W = 4,
    parameter int DW    = 32,
    parameter int AW    = 32
) (
    input  logic             busy,
    input  logic [TAG_W-1:0] base_tag,
    input  logic [DW-1:0]    base_val,
    input  logic [AW-1:0]    a_in,
    input  logic             a_ok_in,
    output logic [AW-1:0]    a_out,
    output logic             a_ok_out
);
    // The offset is replaced by the effective address once, when the base is real.
    always_comb begin
        a_out    = a_in;
        a_ok_out = a_ok_in;
        if (busy && !a_ok_in && (base_tag == '0)) begin
            a_out    = base_val[AW-1:0] + a_in;
            a_ok_out = 1'b1;
        end
    end
endmodule

// File: rtl/lsab_issue_ctrl.sv
module lsab_issue_ctrl #(
    parameter int TAG_W = 4,
    parameter int DW    = 32,
    parameter int AW    = 32
) (
    input  logic             head_busy,
    input  logic             head_store,
    input  logic             head_a_ok,
    input  logic [TAG_W-1:0] head_data_tag,
    input  logic [AW-1:0]    head_addr,
    input  logic [DW-1:0]    head_data,
    input  logic             rd_wait,
    input  logic             mem_req_ready,
    output logic             req_valid,
    output logic             req_write,
    output logic [AW-1:0]    req_addr,
    output logic [DW-1:0]    req_wdata,
    output logic             st_done,
    output logic             rd_start
);
    logic data_ok;

    assign data_ok   = !head_store || (head_data_tag == '0);
    assign req_valid = head_busy && head_a_ok && data_ok && !rd_wait;
    assign req_write = head_store;
    assign req_addr  = head_addr;
    assign req_wdata = head_data;
    assign st_done   = req_valid && mem_req_ready && head_store;
    assign rd_start  = req_valid && mem_req_ready && !head_store;
endmodule

// File: rtl/lsab_mem_buffer.sv
module lsab_mem_buffer
    import lsab_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_is_store,
    input  logic [TAG_W-1:0] alloc_base_tag,
    input  logic [DW-1:0]    alloc_base_val,
    input  logic [AW-1:0]    alloc_offset,
    input  logic [TAG_W-1:0] alloc_data_tag,
    input  logic [DW-1:0]    alloc_data_val,
    output logic             alloc_ready,
    output logic [TAG_W-1:0] alloc_tag,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    input  logic [DW-1:0]    bus_value,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [AW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    input  logic             mem_req_ready,
    input  logic [DW-1:0]    mem_rsp_data,
    output logic             res_valid,
    output logic [TAG_W-1:0] res_tag,
    output logic [DW-1:0]    res_value
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             busy;
        lsab_kind_e       kind;
        logic [TAG_W-1:0] base_tag;
        logic [DW-1:0]    base_val;
        logic [AW-1:0]    a;
        logic             a_ok;
        logic [TAG_W-1:0] data_tag;
        logic [DW-1:0]    data_val;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
        logic              rd_wait;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-slot operand capture and address generation.
    logic [TAG_W-1:0] nb_tag [DEPTH];
    logic [DW-1:0]    nb_val [DEPTH];
    logic [TAG_W-1:0] nd_tag [DEPTH];
    logic [DW-1:0]    nd_val [DEPTH];
    logic [AW-1:0]    na     [DEPTH];
    logic             na_ok  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lsab_snoop #(.TAG_W(TAG_W), .DW(DW)) u_base_snoop (
            .in_tag   (s_q.slot[g].base_tag),
            .in_val   (s_q.slot[g].base_val),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_value(bus_value),
            .out_tag  (nb_tag[g]),
            .out_val  (nb_val[g])
        );
        lsab_snoop #(.TAG_W(TAG_W), .DW(DW)) u_data_snoop (
            .in_tag   (s_q.slot[g].data_tag),
            .in_val   (s_q.slot[g].data_val),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_value(bus_value),
            .out_tag  (nd_tag[g]),
            .out_val  (nd_val[g])
        );
        lsab_agen #(.TAG_W(TAG_W), .DW(DW), .AW(AW)) u_agen (
            .busy    (s_q.slot[g].busy),
            .base_tag(s_q.slot[g].base_tag),
            .base_val(s_q.slot[g].base_val),
            .a_in    (s_q.slot[g].a),
            .a_ok_in (s_q.slot[g].a_ok),
            .a_out   (na[g]),
            .a_ok_out(na_ok[g])
        );
    end

    // Capture of a broadcast arriving in the allocation cycle.
    logic [TAG_W-1:0] ab_tag, ad_tag;
    logic [DW-1:0]    ab_val, ad_val;

    lsab_snoop #(.TAG_W(TAG_W), .DW(DW)) u_alloc_base_snoop (
        .in_tag   (alloc_base_tag),
        .in_val   (alloc_base_val),
        .bus_valid(bus_valid),
        .bus_tag  (bus_tag),
        .bus_value(bus_value),
        .out_tag  (ab_tag),
        .out_val  (ab_val)
    );
    lsab_snoop #(.TAG_W(TAG_W), .DW(DW)) u_alloc_data_snoop (
        .in_tag   (alloc_data_tag),
        .in_val   (alloc_data_val),
        .bus_valid(bus_valid),
        .bus_tag  (bus_tag),
        .bus_value(bus_value),
        .out_tag  (ad_tag),
        .out_val  (ad_val)
    );

    // Oldest-slot request control.
    slot_t head_s;
    logic  st_done, rd_start, take, free_slot;

    assign head_s = s_q.slot[s_q.head];

    lsab_issue_ctrl #(.TAG_W(TAG_W), .DW(DW), .AW(AW)) u_issue (
        .head_busy    (head_s.busy),
        .head_store   (head_s.kind == LSAB_STORE),
        .head_a_ok    (head_s.a_ok),
        .head_data_tag(head_s.data_tag),
        .head_addr    (head_s.a),
        .head_data    (head_s.data_val),
        .rd_wait      (s_q.rd_wait),
        .mem_req_ready(mem_req_ready),
        .req_valid    (mem_req_valid),
        .req_write    (mem_req_write),
        .req_addr     (mem_req_addr),
        .req_wdata    (mem_req_wdata),
        .st_done      (st_done),
        .rd_start     (rd_start)
    );

    assign alloc_ready = (s_q.count != CNT_W'(DEPTH));
    assign alloc_tag   = TAG_W'(TAG_BASE) + TAG_W'(s_q.tail);
    assign take        = alloc_valid && alloc_ready;
    assign free_slot   = st_done || s_q.rd_wait;

    assign res_valid = s_q.rd_wait;
    assign res_tag   = TAG_W'(TAG_BASE) + TAG_W'(s_q.head);
    assign res_value = mem_rsp_data;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < DEPTH; i++) begin
            s_d.slot[i].base_tag = nb_tag[i];
            s_d.slot[i].base_val = nb_val[i];
            s_d.slot[i].data_tag = nd_tag[i];
            s_d.slot[i].data_val = nd_val[i];
            s_d.slot[i].a        = na[i];
            s_d.slot[i].a_ok     = na_ok[i];
        end
        if (free_slot) begin
            s_d.slot[s_q.head].busy = 1'b0;
            s_d.head                = ring_next(s_q.head);
        end
        s_d.rd_wait = rd_start;
        if (take) begin
            s_d.slot[s_q.tail].busy     = 1'b1;
            s_d.slot[s_q.tail].kind     = alloc_is_store ? LSAB_STORE : LSAB_LOAD;
            s_d.slot[s_q.tail].base_tag = ab_tag;
            s_d.slot[s_q.tail].base_val = ab_val;
            s_d.slot[s_q.tail].a        = alloc_offset;
            s_d.slot[s_q.tail].a_ok     = 1'b0;
            s_d.slot[s_q.tail].data_tag = alloc_is_store ? ad_tag : '0;
            s_d.slot[s_q.tail].data_val = ad_val;
            s_d.tail                    = ring_next(s_q.tail);
        end
        s_d.count = s_q.count + CNT_W'(take) - CNT_W'(free_slot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/lsab_mem_buffer_chk.sv
module lsab_mem_buffer_chk #(
    parameter int DEPTH    = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int TAG_W    = 4,
    parameter int TAG_BASE = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             mem_req_valid,
    input logic             mem_req_write,
    input logic [AW-1:0]    mem_req_addr,
    input logic [DW-1:0]    mem_req_wdata,
    input logic             mem_req_ready,
    input logic             res_valid,
    input logic [TAG_W-1:0] res_tag
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic             rd_acc, wr_acc;

    assign rd_acc = mem_req_valid && mem_req_ready && !mem_req_write;
    assign wr_acc = mem_req_valid && mem_req_ready && mem_req_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + OCC_W'(alloc_valid && alloc_ready) - OCC_W'(wr_acc || res_valid);
        end
    end

    a_r2_ready_tracks_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ready == (occ < OCC_W'(DEPTH))) && (occ <= OCC_W'(DEPTH)));

    a_r5_result_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> res_valid);

    a_r5_result_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !res_valid);

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> !mem_req_valid);

    a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)));

    a_r5_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_tag >= TAG_W'(TAG_BASE)) && (res_tag < TAG_W'(TAG_BASE + DEPTH))));
endmodule

bind lsab_mem_buffer lsab_mem_buffer_chk #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready),
    .res_valid    (res_valid),
    .res_tag      (res_tag)
);

// File: tb/lsab_mem_buffer_tb_top.sv
`timescale 1ns/100ps
module lsab_mem_buffer_tb_top;
    localparam int DEPTH = 4, AW = 32, DW = 32, TAG_W = 4, TAG_BASE = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0, alloc_is_store = 1'b0;
    logic [TAG_W-1:0] alloc_base_tag = '0, alloc_data_tag = '0;
    logic [DW-1:0]    alloc_base_val = '0, alloc_data_val = '0;
    logic [AW-1:0]    alloc_offset = '0;
    logic             alloc_ready;
    logic [TAG_W-1:0] alloc_tag;
    logic             bus_valid = 1'b0;
    logic [TAG_W-1:0] bus_tag = '0;
    logic [DW-1:0]    bus_value = '0;
    logic             mem_req_valid, mem_req_write;
    logic [AW-1:0]    mem_req_addr;
    logic [DW-1:0]    mem_req_wdata;
    logic             mem_req_ready = 1'b1;
    logic [DW-1:0]    mem_rsp_data = '0;
    logic             res_valid;
    logic [TAG_W-1:0] res_tag;
    logic [DW-1:0]    res_value;

    int n_chk = 0, n_fail = 0, exp_slot = 0, wr_cnt = 0;
    bit done = 1'b0;
    logic [DW-1:0] mem [64];

    always #2.5 clk = ~clk;

    lsab_mem_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
        .alloc_base_tag(alloc_base_tag), .alloc_base_val(alloc_base_val),
        .alloc_offset(alloc_offset), .alloc_data_tag(alloc_data_tag),
        .alloc_data_val(alloc_data_val), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value)
    );

    // Memory model: one-cycle read data, writes applied on acceptance.
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[7:2]] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_data <= mem[mem_req_addr[7:2]];
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit st, input logic [TAG_W-1:0] bt, input logic [DW-1:0] bv,
                         input logic [AW-1:0] off, input logic [TAG_W-1:0] dt, input logic [DW-1:0] dv);
        alloc_valid = 1'b1; alloc_is_store = st;
        alloc_base_tag = bt; alloc_base_val = bv; alloc_offset = off;
        alloc_data_tag = dt; alloc_data_val = dv;
        chk("R2", "alloc tag", 64'(alloc_tag), 64'(TAG_BASE + exp_slot));
        step();
        alloc_valid = 1'b0;
        exp_slot = (exp_slot + 1) % DEPTH;
    endtask

    task automatic t_reset();
        chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "res_valid", 64'(res_valid), 64'd0);
    endtask

    task automatic t_load_basic();
        int tg;
        tg = TAG_BASE + exp_slot;
        issue(1'b0, 4'd0, 32'h8, 32'h4, 4'd0, '0);
        chk("R3", "no request before address", 64'(mem_req_valid), 64'd0);
        step();
        chk("R3", "request valid", 64'(mem_req_valid), 64'd1);
        chk("R3", "address", 64'(mem_req_addr), 64'hC);
        chk("R5", "read kind", 64'(mem_req_write), 64'd0);
        step();
        chk("R5", "res_valid", 64'(res_valid), 64'd1);
        chk("R5", "res_tag", 64'(res_tag), 64'(tg));
        chk("R5", "res_value", 64'(res_value), 64'(mem[3]));
        step();
        chk("R5", "slot freed", 64'({res_valid, mem_req_valid}), 64'd0);
    endtask

    task automatic t_store_then_load();
        int tg;
        issue(1'b1, 4'd0, 32'h20, 32'h0, 4'd5, '0);
        tg = TAG_BASE + exp_slot;
        issue(1'b0, 4'd0, 32'h1C, 32'h4, 4'd0, '0);
        step(); step();
        chk("R6", "store waits for data", 64'(mem_req_valid), 64'd0);
        chk("R7", "younger load held", 64'(mem_req_valid), 64'd0);
        bus_valid = 1'b1; bus_tag = 4'd5; bus_value = 32'hDEAD_BEEF;
        step();
        bus_valid = 1'b0;
        chk("R6", "write valid", 64'(mem_req_valid), 64'd1);
        chk("R6", "write kind", 64'(mem_req_write), 64'd1);
        chk("R6", "write addr", 64'(mem_req_addr), 64'h20);
        chk("R6", "write data", 64'(mem_req_wdata), 64'hDEAD_BEEF);
        step();
        chk("R6", "no broadcast for store", 64'(res_valid), 64'd0);
        chk("R7", "load follows store", 64'({mem_req_valid, mem_req_write}), 64'b10);
        chk("R7", "load addr", 64'(mem_req_addr), 64'h20);
        step();
        chk("R7", "load sees stored word", 64'(res_value), 64'hDEAD_BEEF);
        chk("R5", "load tag", 64'({res_valid, res_tag}), 64'({1'b1, 4'(tg)}));
        step();
    endtask

    task automatic t_base_pending();
        issue(1'b0, 4'd3, 32'h0, 32'h8, 4'd0, '0);
        step();
        bus_valid = 1'b1; bus_tag = 4'd2; bus_value = 32'h100;
        step();
        chk("R9", "mismatched tag ignored", 64'(mem_req_valid), 64'd0);
        bus_valid = 1'b0; bus_tag = 4'd3; bus_value = 32'h200;
        step();
        chk("R9", "invalid bus ignored", 64'(mem_req_valid), 64'd0);
        bus_valid = 1'b1; bus_tag = 4'd3; bus_value = 32'h40;
        step();
        bus_valid = 1'b0;
        chk("R4", "address one cycle after capture", 64'(mem_req_valid), 64'd0);
        step();
        chk("R4", "request valid", 64'(mem_req_valid), 64'd1);
        chk("R4", "captured base plus offset", 64'(mem_req_addr), 64'h48);
        step();
        chk("R4", "load data", 64'(res_value), 64'(mem[18]));
        step();
    endtask

    task automatic t_alloc_snoop();
        bus_valid = 1'b1; bus_tag = 4'd6; bus_value = 32'h30;
        issue(1'b0, 4'd6, 32'h0, 32'h4, 4'd0, '0);
        bus_valid = 1'b0;
        chk("R8", "not yet requested", 64'(mem_req_valid), 64'd0);
        step();
        chk("R8", "same-cycle capture address", 64'({mem_req_valid, mem_req_addr}), {31'd0, 1'b1, 32'h34});
        step();
        chk("R8", "load data", 64'(res_value), 64'(mem[13]));
        step();
    endtask

    task automatic t_load_stall();
        int t1, t2;
        mem_req_ready = 1'b0;
        t1 = TAG_BASE + exp_slot;
        issue(1'b0, 4'd0, 32'h40, 32'h0, 4'd0, '0);
        t2 = TAG_BASE + exp_slot;
        issue(1'b0, 4'd0, 32'h44, 32'h0, 4'd0, '0);
        step(); step();
        chk("R6", "held request", 64'({mem_req_valid, mem_req_addr}), {31'd0, 1'b1, 32'h40});
        mem_req_ready = 1'b1;
        step();
        chk("R5", "first result", 64'({res_valid, res_tag}), 64'({1'b1, 4'(t1)}));
        chk("R5", "first data", 64'(res_value), 64'(mem[16]));
        chk("R10", "no request while read pending", 64'(mem_req_valid), 64'd0);
        step();
        chk("R10", "second request", 64'({mem_req_valid, mem_req_addr}), {31'd0, 1'b1, 32'h44});
        step();
        chk("R5", "second result", 64'({res_valid, res_tag}), 64'({1'b1, 4'(t2)}));
        chk("R5", "second data", 64'(res_value), 64'(mem[17]));
        step();
    endtask

    task automatic t_full();
        int w0;
        mem_req_ready = 1'b0;
        w0 = wr_cnt;
        for (int i = 0; i < DEPTH; i++) begin
            issue(1'b1, 4'd0, 32'h80 + 32'(4 * i), 32'h0, 4'd0, 32'h5500_0000 + 32'(i));
        end
        chk("R2", "full deasserts ready", 64'(alloc_ready), 64'd0);
        alloc_valid = 1'b1; alloc_is_store = 1'b1; alloc_base_tag = '0;
        alloc_base_val = 32'hF0; alloc_offset = '0; alloc_data_tag = '0; alloc_data_val = 32'h1;
        step();
        alloc_valid = 1'b0;
        chk("R2", "still full", 64'(alloc_ready), 64'd0);
        mem_req_ready = 1'b1;
        step();
        chk("R2", "ready after free", 64'(alloc_ready), 64'd1);
        step(); step(); step();
        chk("R2", "ignored allocation made no write", 64'(wr_cnt - w0), 64'd4);
        chk("R2", "buffer drained", 64'(mem_req_valid), 64'd0);
        chk("R6", "last store data", 64'(mem[35]), 64'h5500_0003);
        chk("R6", "no write from ignored op", 64'(mem[60]), 64'(32'hC0DE_0000 | 32'd60));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_basic();
        t_store_then_load();
        t_base_pending();
        t_alloc_snoop();
        t_load_stall();
        t_full();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule